// File: doc/BRIEF.md
# Reloading 16-bit Interval Timer

A byte-wide, register-mapped interval timer. It holds a 16-bit down-counter and a separate 16-bit reload latch, both reached as pairs of byte registers on a simple host bus. The bus has an address, write data, a write strobe, a read strobe and read data. The counter moves by one only on cycles where the single-cycle clock-enable input is high. When the count passes from zero to all ones, the timer expiry flag is set. An interrupt request is raised whenever that flag and its enable bit are both set.

Two modes are selected by a control bit. In free-running mode the counter takes the latch value again on the tick after it reaches all ones, so one full period is the latch value plus two ticks. In one-shot mode the counter keeps wrapping downward without a reload, and the flag is raised only on the first expiry after a start.

Reads of some registers have side effects. Reading the counter low byte clears the expiry flag. Reading the counter high byte does not. Software that must not lose an expiry therefore samples only the high byte, and reads the flag register on its own.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter, latch, control, flag and enable registers are all zero, every register reads 0x00, and irq is low.
- R2: A write to address 0 (counter low) or address 2 (latch low) changes only the latch low byte. The running count is unaffected.
- R3: A write to address 1 (counter high) stores the data as the latch high byte and, on the same edge, loads the counter with {data, latch low}. That edge also clears the expiry flag and arms one-shot mode. This load takes priority over a tick in the same cycle.
- R4: On each cycle with clkEn high the counter decreases by one, and a count of 0x0000 becomes 0xFFFF. With clkEn low the count holds.
- R5: With control bit 6 set (free-running), the tick after a 0x0000→0xFFFF wrap loads the counter from the latch. The period is therefore latch+2 ticks, and bit 6 of the flag register is set on every wrap.
- R6: With control bit 6 clear (one-shot), the flag is set only on the first wrap after a start. From 0xFFFF the counter goes on to 0xFFFE with no reload.
- R7: Reading address 0 returns the count's low byte and clears the flag at that edge. A wrap in the same cycle wins, and the flag stays set. Reading address 1 returns the high byte (0xFF during the tick after zero) and does not touch the flag.
- R8: Address 5 reads the flag in bit 6 and (flag AND enable) in bit 7, with all other bits zero. Writing it with bit 6 set clears the flag.
- R9: A write to address 6 sets the enable bit if data bit 7 is 1 and clears it if bit 7 is 0, acting only when data bit 6 is 1. Address 6 reads the enable in bit 6 and zero elsewhere. irq equals flag AND enable.
- R10: Addresses 2 and 3 read back the latch low and high bytes, and address 4 reads back the full control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | One-cycle count-enable tick |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (applies the read side effects) |
| rdData | output | 8 | Read data for the current address |
| irq | output | 1 | Interrupt request |

## Verification
A count that is off by one, or a missed reload, shows up in the counter bytes at the very next read. A reload from the wrong place shows up one tick after the wrap, as a wrong byte. A reload one tick early or late moves every later wrap, so a period check made seven ticks after reload shows it. A stale or lost expiry flag is visible in flag bit 6 and in irq in the cycle after the wrap or the clearing access. A one-shot flag that fires again only appears after a full 65536-tick cycle, so the bench runs one.

// File: rtl/itimer_pkg.sv
`timescale 1ns/1ps
package itimer_pkg;

  // Register addresses
  localparam int unsigned ADR_CNT_LO = 0;
  localparam int unsigned ADR_CNT_HI = 1;
  localparam int unsigned ADR_LAT_LO = 2;
  localparam int unsigned ADR_LAT_HI = 3;
  localparam int unsigned ADR_CTRL   = 4;
  localparam int unsigned ADR_FLAG   = 5;
  localparam int unsigned ADR_ENA    = 6;

  // Bit positions decoded by software
  localparam int unsigned TMR_BIT    = 6;  // expiry flag / enable / free-run
  localparam int unsigned ANY_BIT    = 7;  // summary bit / set-clear select

  // Strobes from control to datapath
  typedef struct packed {
    logic latchLoWr;
    logic latchHiWr;
    logic start;
  } dpStrobe_t;

endpackage

// File: rtl/itimer_datapath.sv
`timescale 1ns/1ps
module itimer_datapath
  import itimer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              freeRun,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  latch,
  output logic              reloadPend,
  output logic              expire
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONES = '1;

  logic [DATA_W-1:0] latchLo, latchHi;
  logic [CNT_W-1:0]  cnt;
  logic              pend;
  logic              tick;

  // A load from the bus suppresses the tick of the same cycle
  assign tick   = clkEn & ~strobe.start;
  assign expire = tick & (cnt == CNT_ZERO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchLo <= '0;
      latchHi <= '0;
    end else begin
      if (strobe.latchLoWr) latchLo <= wrData;
      if (strobe.latchHiWr) latchHi <= wrData;
    end
  end

  // pend marks the all-ones state reached through zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (strobe.start) begin
      cnt  <= {wrData, latchLo};
      pend <= 1'b0;
    end else if (tick) begin
      if (cnt == CNT_ZERO) begin
        cnt  <= CNT_ONES;
        pend <= 1'b1;
      end else if (pend && freeRun) begin
        cnt  <= {latchHi, latchLo};
        pend <= 1'b0;
      end else begin
        cnt  <= cnt - 1'b1;
        pend <= 1'b0;
      end
    end
  end

  assign count      = cnt;
  assign latch      = {latchHi, latchLo};
  assign reloadPend = pend;

endmodule

// File: rtl/itimer_ctrl.sv
`timescale 1ns/1ps
module itimer_ctrl
  import itimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  latch,
  output dpStrobe_t         strobe,
  output logic              freeRun,
  output logic              tmrFlag,
  output logic              irq,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] ctrlReg;
  logic              tmrEn;
  logic              armed;

  logic selCntLo, selCntHi, selLatLo, selLatHi, selCtrl, selFlag, selEna;

  assign selCntLo = (addr == ADDR_W'(ADR_CNT_LO));
  assign selCntHi = (addr == ADDR_W'(ADR_CNT_HI));
  assign selLatLo = (addr == ADDR_W'(ADR_LAT_LO));
  assign selLatHi = (addr == ADDR_W'(ADR_LAT_HI));
  assign selCtrl  = (addr == ADDR_W'(ADR_CTRL));
  assign selFlag  = (addr == ADDR_W'(ADR_FLAG));
  assign selEna   = (addr == ADDR_W'(ADR_ENA));

  // Both low-byte addresses write the latch; the high counter byte also starts
  always_comb begin
    strobe.latchLoWr = wrEn & (selCntLo | selLatLo);
    strobe.latchHiWr = wrEn & (selCntHi | selLatHi);
    strobe.start     = wrEn & selCntHi;
  end

  assign freeRun = ctrlReg[TMR_BIT];

  logic flagSet, flagClr;
  assign flagSet = expire & (freeRun | armed);
  assign flagClr = strobe.start
                 | (rdEn & selCntLo)
                 | (wrEn & selFlag & wrData[TMR_BIT]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      tmrFlag <= 1'b0;
      tmrEn   <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (wrEn && selCtrl) ctrlReg <= wrData;

      // A fresh expiry outranks any clearing access
      if (flagSet)      tmrFlag <= 1'b1;
      else if (flagClr) tmrFlag <= 1'b0;

      if (strobe.start)           armed <= 1'b1;
      else if (expire && !freeRun) armed <= 1'b0;

      if (wrEn && selEna && wrData[TMR_BIT])
        tmrEn <= wrData[ANY_BIT];
    end
  end

  assign irq = tmrFlag & tmrEn;

  always_comb begin
    rdData = '0;
    if (selCntLo) rdData = count[DATA_W-1:0];
    if (selCntHi) rdData = count[CNT_W-1:DATA_W];
    if (selLatLo) rdData = latch[DATA_W-1:0];
    if (selLatHi) rdData = latch[CNT_W-1:DATA_W];
    if (selCtrl)  rdData = ctrlReg;
    if (selFlag) begin
      rdData[TMR_BIT] = tmrFlag;
      rdData[ANY_BIT] = irq;
    end
    if (selEna)   rdData[TMR_BIT] = tmrEn;
  end

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
  import itimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int CNT_W = 2 * DATA_W;

  dpStrobe_t        strobe;
  logic             freeRun;
  logic             tmrFlag;
  logic             expire;
  logic             reloadPend;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] latch;

  itimer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .wrData  (wrData),
    .expire  (expire),
    .count   (count),
    .latch   (latch),
    .strobe  (strobe),
    .freeRun (freeRun),
    .tmrFlag (tmrFlag),
    .irq     (irq),
    .rdData  (rdData)
  );

  itimer_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .clkEn      (clkEn),
    .freeRun    (freeRun),
    .strobe     (strobe),
    .wrData     (wrData),
    .count      (count),
    .latch      (latch),
    .reloadPend (reloadPend),
    .expire     (expire)
  );

endmodule

// File: rtl/itimer_checker.sv
`timescale 1ns/1ps
module itimer_checker
  import itimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  latch,
  input logic              reloadPend,
  input logic              freeRun,
  input logic              tmrFlag,
  input logic              irq
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic startW, zeroTick;
  assign startW   = wrEn && (addr == ADDR_W'(ADR_CNT_HI));
  assign zeroTick = clkEn && !startW && (count == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    startW |=> (count == latch) && !tmrFlag);

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    zeroTick |=> (count == ALL_ONES));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !startW) |=> $stable(count));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !wrEn && freeRun && reloadPend) |=> (count == $past(latch)));

  assert_no_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !wrEn && !freeRun && reloadPend) |=> (count == ALL_ONES - 1'b1));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == ADDR_W'(ADR_CNT_LO)) && !zeroTick) |=> !tmrFlag);

  assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> tmrFlag);

endmodule

bind interval_timer itimer_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkEn      (clkEn),
  .addr       (addr),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .count      (count),
  .latch      (latch),
  .reloadPend (reloadPend),
  .freeRun    (freeRun),
  .tmrFlag    (tmrFlag),
  .irq        (irq)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_TK  = 2'd2;
  localparam logic [1:0] OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] adr;
    logic [7:0] data;
    logic [7:0] expv;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 39;
  localparam vec_t VEC [NVEC] = '{
    '{OP_WR, 4'h4, 8'h40, 8'h00, 4'd10}, // R10 free-running
    '{OP_WR, 4'h6, 8'hC0, 8'h00, 4'd9},  // R9 enable set
    '{OP_WR, 4'h2, 8'h05, 8'h00, 4'd2},  // R2 latch low = 5
    '{OP_WR, 4'h1, 8'h00, 8'h00, 4'd3},  // R3 start, count 0x0005
    '{OP_RD, 4'h0, 8'h00, 8'h05, 4'd3},
    '{OP_RD, 4'h1, 8'h00, 8'h00, 4'd3},
    '{OP_TK, 4'h0, 8'd5,  8'h00, 4'd4},  // R4 down to zero
    '{OP_RD, 4'h0, 8'h00, 8'h00, 4'd4},
    '{OP_RD, 4'h5, 8'h00, 8'h00, 4'd5},
    '{OP_TK, 4'h0, 8'd1,  8'h00, 4'd4},  // zero -> all ones
    '{OP_RD, 4'h1, 8'h00, 8'hFF, 4'd7},  // R7 high read, no clear
    '{OP_RD, 4'h5, 8'h00, 8'hC0, 4'd8},  // R8 flag + summary
    '{OP_IRQ,4'h0, 8'h00, 8'h01, 4'd9},
    '{OP_TK, 4'h0, 8'd1,  8'h00, 4'd5},  // R5 reload
    '{OP_RD, 4'h1, 8'h00, 8'h00, 4'd5},
    '{OP_RD, 4'h0, 8'h00, 8'h05, 4'd5},  // clears flag
    '{OP_RD, 4'h5, 8'h00, 8'h00, 4'd7},
    '{OP_IRQ,4'h0, 8'h00, 8'h00, 4'd9},
    '{OP_TK, 4'h0, 8'd7,  8'h00, 4'd5},  // one full period latch+2
    '{OP_RD, 4'h5, 8'h00, 8'hC0, 4'd5},
    '{OP_RD, 4'h0, 8'h00, 8'h05, 4'd5},
    '{OP_RD, 4'h5, 8'h00, 8'h00, 4'd7},
    '{OP_WR, 4'h0, 8'h09, 8'h00, 4'd2},  // R2 counter low write hits latch
    '{OP_RD, 4'h0, 8'h00, 8'h05, 4'd2},
    '{OP_RD, 4'h2, 8'h00, 8'h09, 4'd10},
    '{OP_RD, 4'h3, 8'h00, 8'h00, 4'd10},
    '{OP_WR, 4'h1, 8'h01, 8'h00, 4'd3},  // count 0x0109
    '{OP_RD, 4'h1, 8'h00, 8'h01, 4'd3},
    '{OP_RD, 4'h0, 8'h00, 8'h09, 4'd3},
    '{OP_RD, 4'h3, 8'h00, 8'h01, 4'd10},
    '{OP_WR, 4'h4, 8'h00, 8'h00, 4'd6},  // R6 one-shot
    '{OP_RD, 4'h4, 8'h00, 8'h00, 4'd10},
    '{OP_WR, 4'h2, 8'h02, 8'h00, 4'd6},
    '{OP_WR, 4'h1, 8'h00, 8'h00, 4'd6},  // count 0x0002
    '{OP_TK, 4'h0, 8'd3,  8'h00, 4'd6},
    '{OP_RD, 4'h5, 8'h00, 8'hC0, 4'd6},
    '{OP_TK, 4'h0, 8'd1,  8'h00, 4'd6},  // no reload
    '{OP_RD, 4'h1, 8'h00, 8'hFF, 4'd6},
    '{OP_RD, 4'h0, 8'h00, 8'hFE, 4'd6}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       clkEn;
  logic [3:0] addr;
  logic       wrEn;
  logic [7:0] wrData;
  logic       rdEn;
  logic [7:0] rdData;
  logic       irq;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  interval_timer u_interval_timer (
    .clk    (clk),
    .rstN   (rstN),
    .clkEn  (clkEn),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdEn   (rdEn),
    .rdData (rdData),
    .irq    (irq)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [7:0] expv, input string tag);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1;
    check(rdData == expv, tag, rdData, expv);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic irqChk(input logic expv, input string tag);
    @(negedge clk);
    #1;
    check(irq == expv, tag, {7'd0, irq}, {7'd0, expv});
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      @(negedge clk);
      clkEn = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      clkEn = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; clkEn = 1'b0; addr = '0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register and irq
    for (int a = 0; a < 7; a++) rdChk(4'(a), 8'h00, "R1");
    irqChk(1'b0, "R1");

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        OP_WR:   wr(VEC[i].adr, VEC[i].data);
        OP_RD:   rdChk(VEC[i].adr, VEC[i].expv, tag);
        OP_TK:   tick(int'(VEC[i].data));
        default: irqChk(VEC[i].expv[0], tag);
      endcase
    end

    // R6: second wrap in one-shot mode leaves the flag clear
    tick(65535);
    rdChk(4'h5, 8'h00, "R6 second wrap");
    rdChk(4'h1, 8'hFF, "R6 wrapped high");
    rdChk(4'h0, 8'hFF, "R6 wrapped low");

    // R8: write-one-to-clear of the flag
    wr(4'h4, 8'h40);
    wr(4'h2, 8'h00);
    wr(4'h1, 8'h00);
    tick(1);
    rdChk(4'h5, 8'hC0, "R5 zero latch wrap");
    wr(4'h5, 8'h40);
    rdChk(4'h5, 8'h00, "R8 write clear");
    tick(1);
    rdChk(4'h0, 8'h00, "R5 reload zero latch");
    tick(1);

    // R9: enable clear and set, irq follows
    wr(4'h6, 8'h40);
    rdChk(4'h6, 8'h00, "R9 enable cleared");
    rdChk(4'h5, 8'h40, "R9 flag without summary");
    irqChk(1'b0, "R9 irq masked");
    wr(4'h6, 8'hC0);
    rdChk(4'h6, 8'h40, "R9 enable set");
    irqChk(1'b1, "R9 irq raised");

    // R3: counter high write clears the flag
    wr(4'h1, 8'h00);
    rdChk(4'h5, 8'h00, "R3 start clears flag");
    irqChk(1'b0, "R3 irq dropped");

    finishRun();
  end

endmodule